// File: doc/BRIEF.md
# Baseband Digital Gain Control Loop

This block applies a programmable digital gain to a complex baseband stream of 12-bit signed I and Q samples, and can adjust that gain automatically. Each sample is multiplied by a 16-bit unsigned gain with 12 fractional bits, so 0x1000 is unity and 0xFFFF is just under sixteen. The product is shifted down and saturated to the 12-bit output range. A sample counts as clipped when either lane had to be saturated. The scaled pair comes out one clock after the input, with its own valid flag.

A 2-bit mode selects how the gain moves. In fixed mode the gain stays where software put it. In local mode the block lowers the gain quickly whenever it sees clipping, and raises it slowly after a long run of clean samples, which keeps the output as large as possible without saturating. In external mode a single pin driven by a downstream stage steers the gain up or down at a fixed sample cadence. In every mode the gain starts from a value written as two bytes, and the current gain can be read back as two bytes.

Top module: `agc_baseband`

## Requirements
- R1: When `in_valid` is high, the next clock edge registers `out_i` = floor(`in_i` * gain / 4096) and `out_q` = floor(`in_q` * gain / 4096), each saturated to [-2048, 2047], and raises `out_valid` for one cycle. The gain used is the value before that edge. With `in_valid` low, `out_valid` is 0 and `out_i`/`out_q` hold their values.
- R2: Reset gives gain 0x1000, stored seed low byte 0x00, `out_valid` 0, and `out_i`/`out_q` 0.
- R3: A `seed_lo_we` pulse stores `seed_data` as the seed low byte and leaves the gain untouched. A `seed_hi_we` pulse loads the gain with {`seed_data`, stored low byte}, using the low byte held before that cycle.
- R4: In mode 0 (fixed) and mode 3 (also fixed), the gain changes only through a high-byte write, even when samples clip.
- R5: In mode 1 (local), a valid sample in which either lane is clipped lowers the gain by 256 at that edge.
- R6: In mode 1, the 1024th consecutive valid unclipped sample raises the gain by 16. A clipped sample restarts this count.
- R7: In mode 2 (external), the gain moves on every 256th valid sample: down 64 if `agc_ext` is 1 in that cycle, and up 64 if it is 0. Clipping has no effect in this mode.
- R8: The gain saturates at 0 and 0xFFFF and never wraps.
- R9: When a high-byte write and a loop step fall in the same cycle, the written value is loaded and the step is dropped. The sample count restarts from zero.
- R10: In any cycle where `mode` differs from its value in the previous cycle, the sample count restarts and no loop step occurs.
- R11: `gain_rd_hi`/`gain_rd_lo` always show the current gain's upper and lower bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 fixed, 1 local loop, 2 external pin, 3 fixed |
| seed_lo_we | input | 1 | Store `seed_data` as the seed low byte |
| seed_hi_we | input | 1 | Load the gain from `seed_data` and the stored low byte |
| seed_data | input | 8 | Seed byte |
| agc_ext | input | 1 | External steering: 1 lowers the gain, 0 raises it |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | Input I sample, signed |
| in_q | input | 12 | Input Q sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 12 | Scaled I sample, signed |
| out_q | output | 12 | Scaled Q sample, signed |
| gain_rd_lo | output | 8 | Current gain, bits 7:0 |
| gain_rd_hi | output | 8 | Current gain, bits 15:8 |

## Verification
A software reload of the gain and a loop adjustment can land on the same clock edge. The bench provokes this twice with a high-byte write. The first write sits on a clipped sample in local mode. The second sits exactly on the 256th sample in external mode. The reload is judged correct when the readback equals the written seed with no step applied, and when the next step arrives only after a full new window counted from that cycle. The bench also interleaves random mode changes and seed writes with random samples so that these collisions recur.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_LOCAL = 2'd1,
    MODE_EXT   = 2'd2,
    MODE_HOLD  = 2'd3
  } agc_mode_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/agc_scaler.sv
module agc_scaler #(
  parameter int DW   = 12,
  parameter int GW   = 16,
  parameter int FRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [GW-1:0]        gain,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic                 clip
);

  localparam int PW = DW + GW + 1;
  localparam int NL = 2;
  localparam logic signed [PW-1:0] MAXV = $signed({{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [PW-1:0] MINV = $signed({{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}});

  logic [NL*DW-1:0] in_all;
  logic [NL*DW-1:0] sat_all;
  logic [NL-1:0]    clip_all;

  assign in_all = {in_q, in_i};

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shv;
    logic signed [DW-1:0] lsat;
    logic                 lclip;

    always_comb begin
      prod = PW'($signed(in_all[k*DW +: DW])) * PW'($signed({1'b0, gain}));
      shv  = prod >>> FRAC;
      if (shv > MAXV) begin
        lsat  = MAXV[DW-1:0];
        lclip = 1'b1;
      end else if (shv < MINV) begin
        lsat  = MINV[DW-1:0];
        lclip = 1'b1;
      end else begin
        lsat  = shv[DW-1:0];
        lclip = 1'b0;
      end
    end

    assign sat_all[k*DW +: DW] = lsat;
    assign clip_all[k]         = lclip;
  end

  assign clip = |clip_all;

  logic                 vld_d;
  logic signed [DW-1:0] oi_d;
  logic signed [DW-1:0] oq_d;

  always_comb begin
    vld_d = in_valid;
    oi_d  = in_valid ? sat_all[DW-1:0]    : out_i;
    oq_d  = in_valid ? sat_all[2*DW-1:DW] : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= vld_d;
      out_i     <= oi_d;
      out_q     <= oq_d;
    end
  end

  // R1
  out_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));

endmodule

// File: rtl/agc_step_ctrl.sv
module agc_step_ctrl #(
  parameter int GW         = 16,
  parameter int LOC_WIN    = 1024,
  parameter int EXT_PERIOD = 256,
  parameter int DN_STEP    = 256,
  parameter int UP_STEP    = 16,
  parameter int EXT_STEP   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  agc_pkg::agc_mode_e   mode,
  input  logic                 sample_valid,
  input  logic                 clip,
  input  logic                 ext_dn,
  input  logic                 reload,
  output agc_pkg::step_e       cmd,
  output logic [GW-1:0]        amount
);

  import agc_pkg::*;

  localparam int CNT_MAX = (LOC_WIN > EXT_PERIOD) ? LOC_WIN : EXT_PERIOD;
  localparam int CW      = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;
  localparam logic [CW-1:0] LOC_LAST = CW'(LOC_WIN - 1);
  localparam logic [CW-1:0] EXT_LAST = CW'(EXT_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  agc_mode_e     mode_q;

  always_comb begin
    cnt_d  = cnt_q;
    cmd    = STEP_HOLD;
    amount = '0;
    if (mode != mode_q) begin
      cnt_d = '0;
    end else begin
      case (mode)
        MODE_LOCAL: begin
          if (sample_valid) begin
            if (clip) begin
              cnt_d  = '0;
              cmd    = STEP_DOWN;
              amount = GW'(DN_STEP);
            end else if (cnt_q == LOC_LAST) begin
              cnt_d  = '0;
              cmd    = STEP_UP;
              amount = GW'(UP_STEP);
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        MODE_EXT: begin
          if (sample_valid) begin
            if (cnt_q == EXT_LAST) begin
              cnt_d  = '0;
              cmd    = ext_dn ? STEP_DOWN : STEP_UP;
              amount = GW'(EXT_STEP);
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        default: cnt_d = '0;
      endcase
    end
    if (reload) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= MODE_FIXED;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode;
    end
  end

  // R5
  local_dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == STEP_DOWN && mode == MODE_LOCAL) |-> (sample_valid && clip));

  // R7
  ext_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != STEP_HOLD && mode == MODE_EXT) |-> ((cmd == STEP_DOWN) == ext_dn));

  // R10
  mode_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |-> (cmd == STEP_HOLD));

endmodule

// File: rtl/agc_gain_reg.sv
module agc_gain_reg #(
  parameter int            GW         = 16,
  parameter logic [GW-1:0] RESET_GAIN = 16'h1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lo_we,
  input  logic                 hi_we,
  input  logic [GW/2-1:0]      wdata,
  input  agc_pkg::step_e       cmd,
  input  logic [GW-1:0]        amount,
  output logic [GW-1:0]        gain
);

  import agc_pkg::*;

  localparam int BW = GW / 2;

  logic [GW-1:0] gain_q, gain_d;
  logic [BW-1:0] lo_q, lo_d;
  logic [GW:0]   sum;

  always_comb begin
    sum  = {1'b0, gain_q} + {1'b0, amount};
    lo_d = lo_we ? wdata : lo_q;
    if (hi_we) begin
      gain_d = {wdata, lo_q};
    end else begin
      case (cmd)
        STEP_UP:   gain_d = sum[GW] ? '1 : sum[GW-1:0];
        STEP_DOWN: gain_d = (gain_q < amount) ? '0 : (gain_q - amount);
        default:   gain_d = gain_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= RESET_GAIN;
      lo_q   <= RESET_GAIN[BW-1:0];
    end else begin
      gain_q <= gain_d;
      lo_q   <= lo_d;
    end
  end

  assign gain = gain_q;

  // R3
  lo_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we && cmd == STEP_HOLD) |=> $stable(gain_q));

  // R9
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> (gain_q == $past({wdata, lo_q})));

  // R8
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_we && cmd == STEP_UP) |=> (gain_q >= $past(gain_q)));

  // R8
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_we && cmd == STEP_DOWN) |=> (gain_q <= $past(gain_q)));

endmodule

// File: rtl/agc_baseband.sv
module agc_baseband #(
  parameter int            DW         = 12,
  parameter int            GW         = 16,
  parameter int            FRAC       = 12,
  parameter int            LOC_WIN    = 1024,
  parameter int            EXT_PERIOD = 256,
  parameter int            DN_STEP    = 256,
  parameter int            UP_STEP    = 16,
  parameter int            EXT_STEP   = 64,
  parameter logic [GW-1:0] RESET_GAIN = 16'h1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 seed_lo_we,
  input  logic                 seed_hi_we,
  input  logic [GW/2-1:0]      seed_data,
  input  logic                 agc_ext,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic [GW/2-1:0]      gain_rd_lo,
  output logic [GW/2-1:0]      gain_rd_hi
);

  import agc_pkg::*;

  localparam int BW = GW / 2;

  agc_mode_e     mode_e;
  step_e         cmd;
  logic [GW-1:0] amount;
  logic [GW-1:0] gain;
  logic          clip;

  assign mode_e = agc_mode_e'(mode);

  agc_scaler #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_scaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .gain      (gain),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .clip      (clip)
  );

  agc_step_ctrl #(
    .GW(GW), .LOC_WIN(LOC_WIN), .EXT_PERIOD(EXT_PERIOD),
    .DN_STEP(DN_STEP), .UP_STEP(UP_STEP), .EXT_STEP(EXT_STEP)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode_e),
    .sample_valid (in_valid),
    .clip         (clip),
    .ext_dn       (agc_ext),
    .reload       (seed_hi_we),
    .cmd          (cmd),
    .amount       (amount)
  );

  agc_gain_reg #(.GW(GW), .RESET_GAIN(RESET_GAIN)) u_gain (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_we  (seed_lo_we),
    .hi_we  (seed_hi_we),
    .wdata  (seed_data),
    .cmd    (cmd),
    .amount (amount),
    .gain   (gain)
  );

  assign gain_rd_lo = gain[BW-1:0];
  assign gain_rd_hi = gain[GW-1:BW];

  // R4
  fixed_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_hi_we && (mode_e == MODE_FIXED || mode_e == MODE_HOLD)) |=> (gain == $past(gain)));

  // R7
  ext_ignores_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_EXT && !seed_hi_we && cmd == STEP_HOLD) |=> $stable(gain));

endmodule

// File: tb/tb_agc_baseband.sv
`timescale 1ns/1ps
module tb_agc_baseband;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic seed_lo_we, seed_hi_we;
  logic [7:0] seed_data;
  logic agc_ext, in_valid;
  logic signed [11:0] in_i, in_q;
  logic out_valid;
  logic signed [11:0] out_i, out_q;
  logic [7:0] gain_rd_lo, gain_rd_hi;

  always #4 clk = ~clk;

  agc_baseband dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .seed_lo_we(seed_lo_we),
    .seed_hi_we(seed_hi_we), .seed_data(seed_data), .agc_ext(agc_ext),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .gain_rd_lo(gain_rd_lo), .gain_rd_hi(gain_rd_hi)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R2";

  logic [15:0] m_gain;
  logic [7:0]  m_lo;
  int          m_cnt;
  logic [1:0]  m_mq;
  logic        exp_ov;
  logic signed [11:0] exp_i, exp_q;
  logic [1:0]  cm;

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void scale(input logic signed [11:0] x, input logic [15:0] g,
                                output logic signed [11:0] y, output bit c);
    longint p;
    p = (longint'(x) * longint'(g)) >>> 12;
    if (p > 2047) begin y = 12'h7FF; c = 1'b1; end
    else if (p < -2048) begin y = 12'h800; c = 1'b1; end
    else begin y = 12'(p); c = 1'b0; end
  endfunction

  function automatic logic signed [11:0] small_s();
    int t;
    t = int'($urandom_range(200)) - 100;
    return 12'(t);
  endfunction

  function automatic logic signed [11:0] any_s();
    return 12'($urandom);
  endfunction

  // one clock: drive, advance the model from the requirements, check outputs
  task automatic cyc(bit v, logic signed [11:0] xi, logic signed [11:0] xq, logic [1:0] md,
                     bit ext, bit lwe, bit hwe, logic [7:0] d);
    logic signed [11:0] yi, yq;
    bit ci, cq, clipped;
    int ncnt, step, amt;
    logic [15:0] ng;
    @(negedge clk);
    in_valid = v; in_i = xi; in_q = xq; mode = md; agc_ext = ext;
    seed_lo_we = lwe; seed_hi_we = hwe; seed_data = d;
    scale(xi, m_gain, yi, ci);
    scale(xq, m_gain, yq, cq);
    clipped = ci | cq;
    ncnt = m_cnt; step = 0; amt = 0;
    if (md != m_mq) ncnt = 0;
    else if (md == 2'd1) begin
      if (v) begin
        if (clipped) begin ncnt = 0; step = -1; amt = 256; end
        else if (m_cnt == 1023) begin ncnt = 0; step = 1; amt = 16; end
        else ncnt = m_cnt + 1;
      end
    end else if (md == 2'd2) begin
      if (v) begin
        if (m_cnt == 255) begin ncnt = 0; step = ext ? -1 : 1; amt = 64; end
        else ncnt = m_cnt + 1;
      end
    end else ncnt = 0;
    if (hwe) begin ncnt = 0; ng = {d, m_lo}; end
    else if (step == 1) ng = (int'(m_gain) + amt > 65535) ? 16'hFFFF : 16'(int'(m_gain) + amt);
    else if (step == -1) ng = (int'(m_gain) < amt) ? 16'h0000 : 16'(int'(m_gain) - amt);
    else ng = m_gain;
    if (lwe) m_lo = d;
    m_gain = ng; m_cnt = ncnt; m_mq = md;
    exp_ov = v;
    if (v) begin exp_i = yi; exp_q = yq; end
    @(posedge clk);
    #2;
    chk("R1", "out_valid", longint'(out_valid), longint'(exp_ov));
    chk("R1", "out_i", longint'(out_i), longint'(exp_i));
    chk("R1", "out_q", longint'(out_q), longint'(exp_q));
    chk(cur_req, "gain readback (R11)", longint'({gain_rd_hi, gain_rd_lo}), longint'(m_gain));
  endtask

  task automatic seed(logic [15:0] g);
    cyc(1'b0, 12'sd0, 12'sd0, cm, 1'b0, 1'b1, 1'b0, g[7:0]);
    cyc(1'b0, 12'sd0, 12'sd0, cm, 1'b0, 1'b0, 1'b1, g[15:8]);
  endtask

  task automatic gain_is(string req, string what, logic [15:0] g);
    chk(req, what, longint'({gain_rd_hi, gain_rd_lo}), longint'(g));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] g0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; mode = 2'd0; seed_lo_we = 1'b0; seed_hi_we = 1'b0; seed_data = 8'h00;
    agc_ext = 1'b0; in_valid = 1'b0; in_i = 12'sd0; in_q = 12'sd0;
    m_gain = 16'h1000; m_lo = 8'h00; m_cnt = 0; m_mq = 2'd0;
    exp_ov = 1'b0; exp_i = 12'sd0; exp_q = 12'sd0; cm = 2'd0;
    repeat (3) @(posedge clk);
    #2;
    chk("R2", "out_valid in reset", longint'(out_valid), 0);
    chk("R2", "out_i in reset", longint'(out_i), 0);
    gain_is("R2", "gain in reset (R11)", 16'h1000);
    @(negedge clk); rst_n = 1'b1;

    // R1 directed corners at unity and maximum gain
    cur_req = "R1";
    cyc(1'b1, 12'sh800, 12'sh7FF, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1", "unity min", longint'(out_i), -2048);
    chk("R1", "unity max", longint'(out_q), 2047);
    seed(16'hFFFF);
    cyc(1'b1, 12'sd2047, -12'sd1, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1", "max gain clip", longint'(out_i), 2047);
    chk("R1", "floor of -1 at max gain", longint'(out_q), -16);
    cyc(1'b0, 12'sd5, 12'sd5, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1", "hold without valid", longint'(out_i), 2047);

    // R4 fixed modes under clipping
    cur_req = "R4";
    seed(16'h3000);
    for (int n = 0; n < 200; n++)
      cyc($urandom_range(3) != 0, any_s(), any_s(), cm, 1'($urandom), 1'b0, 1'b0, 8'h00);
    gain_is("R4", "mode 0 held", 16'h3000);
    cm = 2'd3;
    seed(16'h8000);
    for (int n = 0; n < 200; n++)
      cyc(1'b1, any_s(), any_s(), cm, 1'($urandom), 1'b0, 1'b0, 8'h00);
    gain_is("R4", "mode 3 held", 16'h8000);

    // R3 low byte alone is inert, high byte loads
    cur_req = "R3";
    cm = 2'd0;
    cyc(1'b0, 12'sd0, 12'sd0, cm, 1'b0, 1'b1, 1'b0, 8'h55);
    gain_is("R3", "low write only", 16'h8000);
    cyc(1'b0, 12'sd0, 12'sd0, cm, 1'b0, 1'b0, 1'b1, 8'h12);
    gain_is("R3", "high write loads", 16'h1255);

    // R5 clip burst in local mode
    cur_req = "R5";
    seed(16'h4000);
    cm = 2'd1;
    cyc(1'b0, 12'sd0, 12'sd0, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, 12'sd1500, 12'sd0, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R5", "first clip step", 16'h3F00);
    for (int n = 0; n < 60; n++)
      cyc(1'b1, 12'sd1500, -12'sd1500, cm, 1'b0, 1'b0, 1'b0, 8'h00);

    // R6 window increase and restart on clip
    cur_req = "R6";
    seed(16'h1000);
    for (int n = 0; n < 1023; n++)
      cyc(1'b1, small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R6", "before window end", 16'h1000);
    cyc(1'b1, small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R6", "window end", 16'h1010);
    for (int n = 0; n < 500; n++)
      cyc(1'b1, small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, 12'sh800, 12'sd0, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R6", "clip mid window", 16'h0F10);
    for (int n = 0; n < 1023; n++)
      cyc(($urandom_range(7) != 0) || (n > 1000), small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);

    // R7 external steering
    cur_req = "R7";
    cm = 2'd2;
    seed(16'h1000);
    for (int n = 0; n < 255; n++)
      cyc(1'b1, any_s(), any_s(), cm, 1'b1, 1'b0, 1'b0, 8'h00);
    gain_is("R7", "before 256th", 16'h1000);
    cyc(1'b1, 12'sh800, 12'sh800, cm, 1'b1, 1'b0, 1'b0, 8'h00);
    gain_is("R7", "down step", 16'h0FC0);
    for (int n = 0; n < 256; n++)
      cyc(1'b1, small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R7", "up step", 16'h1000);
    for (int n = 0; n < 800; n++)
      cyc($urandom_range(3) != 0, any_s(), any_s(), cm, 1'($urandom), 1'b0, 1'b0, 8'h00);

    // R8 saturation at both ends
    cur_req = "R8";
    seed(16'h0020);
    for (int n = 0; n < 600; n++)
      cyc(1'b1, any_s(), any_s(), cm, 1'b1, 1'b0, 1'b0, 8'h00);
    gain_is("R8", "floor at zero", 16'h0000);
    seed(16'hFFE0);
    for (int n = 0; n < 600; n++)
      cyc(1'b1, small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R8", "ceiling", 16'hFFFF);

    // R9 reload and step in the same cycle
    cur_req = "R9";
    cm = 2'd1;
    seed(16'h4000);
    cyc(1'b0, 12'sd0, 12'sd0, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, 12'sd2000, 12'sd0, cm, 1'b0, 1'b0, 1'b1, 8'h50);
    gain_is("R9", "reload on clip", 16'h5000);
    cm = 2'd2;
    seed(16'h2000);
    for (int n = 0; n < 255; n++)
      cyc(1'b1, small_s(), small_s(), cm, 1'b1, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, small_s(), small_s(), cm, 1'b1, 1'b0, 1'b1, 8'h30);
    gain_is("R9", "reload on 256th", 16'h3000);
    for (int n = 0; n < 255; n++)
      cyc(1'b1, small_s(), small_s(), cm, 1'b1, 1'b0, 1'b0, 8'h00);
    gain_is("R9", "count restarted", 16'h3000);
    cyc(1'b1, small_s(), small_s(), cm, 1'b1, 1'b0, 1'b0, 8'h00);
    gain_is("R9", "step after restart", 16'h2FC0);

    // R10 mode change restarts the window
    cur_req = "R10";
    cm = 2'd1;
    seed(16'h1000);
    cyc(1'b0, 12'sd0, 12'sd0, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int n = 0; n < 1000; n++)
      cyc(1'b1, small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(1'b0, 12'sd0, 12'sd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, 12'sh800, 12'sd0, cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R10", "no step on change cycle", 16'h1000);
    for (int n = 0; n < 1023; n++)
      cyc(1'b1, small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R10", "window restarted", 16'h1000);
    cyc(1'b1, small_s(), small_s(), cm, 1'b0, 1'b0, 1'b0, 8'h00);
    gain_is("R10", "full window", 16'h1010);

    // mixed random traffic with collisions
    cur_req = "R9";
    for (int n = 0; n < 4000; n++) begin
      bit lw, hw;
      if ($urandom_range(49) == 0) cm = 2'($urandom);
      lw = ($urandom_range(99) == 0);
      hw = ($urandom_range(99) == 0);
      g0 = 16'($urandom);
      cyc($urandom_range(9) < 7, ($urandom_range(1) == 0) ? small_s() : any_s(),
          any_s(), cm, 1'($urandom), lw, hw, g0[7:0]);
    end

    finish_up();
  end

endmodule